// File: doc/BRIEF.md
# Dual-Channel Memory-to-Memory Byte Mover

This block copies blocks of bytes from one memory region to another without help from the processor. It has two channels, each programmed through a small register file with a 24-bit source pointer, a 24-bit destination pointer, a 16-bit byte count and a control byte. After software sets a channel's enable bit, the block asks the processor for the bus. Once the processor acknowledges, the block moves each byte with a read at the source pointer and then a write at the destination pointer. When a channel's count runs out, the block can raise that channel's interrupt.

Each channel runs in one of two modes. In burst mode it keeps the bus until its whole block has been copied. In cycle-steal mode it moves one byte per bus ownership and then stays off the bus for a fixed eight clocks. Each channel steps its source pointer and its destination pointer on their own: up by one, down by one, or not at all. The block also decides between its own channels and an external bus master that asks for the bus with an active-low request. Its own channels win that contest.

Top module: `dmx_mover`

## Requirements
- R1: After reset every register reads as zero, both channels are disabled, `bus_req`, `mem_rd`, `mem_wr`, `ext_grant` and both `irq` bits are low.
- R2: Register address bit 4 selects the channel. Within a channel, index 0-2 hold the source pointer (least significant byte first), 3-5 the destination pointer, 6-7 the byte count and 8 the control byte. Other indices read as zero. Written values read back unchanged, except control bit 7.
- R3: Each byte takes one `mem_rd` clock at the source pointer, followed at once by one `mem_wr` clock at the destination pointer. `mem_wdata` carries the value that `mem_rdata` held during the read clock.
- R4: Control bits [3:2] set the source step and bits [5:4] set the destination step: 00 adds one, 01 subtracts one, 1x leaves the pointer unchanged. Pointers wrap modulo 2^24. The updated pointers read back through the register file.
- R5: With control bit 1 clear (burst), all bytes of a channel are moved back to back, with a read in the clock right after each write except the last.
- R6: With control bit 1 set (cycle-steal), the block drops `bus_req` for exactly eight clocks after each byte except the last, then requests again.
- R7: When the count reaches zero, the channel clears its enable bit (control bit 0) and sets its done flag (control bit 7). `irq[n]` equals done AND interrupt-enable (control bit 6). Any write to the control byte clears done.
- R8: Enabling a channel with a zero count sets done and clears enable without any request or bus cycle.
- R9: If the channels and the external request (`ext_breq_n` low) are pending at the same acknowledge, a channel gets the bus. While a channel holds the bus, `ext_grant` stays low. The external master is granted after the channel releases the bus. While the external master holds the bus, no channel strobes.
- R10: A disabled channel never raises `bus_req`. Strobes occur only while `cpu_ack` is high.
- R11: When both channels are pending at a grant, channel 0 is served first. The choice is made only when the bus is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address: bit 4 channel, bits 3:0 index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| bus_req | output | 1 | Bus request to the processor |
| cpu_ack | input | 1 | Processor bus acknowledge |
| ext_breq_n | input | 1 | External master bus request, active low |
| ext_grant | output | 1 | Bus granted to the external master |
| mem_addr | output | 24 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |
| mem_rd | output | 1 | Read strobe, one clock per read |
| mem_wr | output | 1 | Write strobe, one clock per write |
| irq | output | 2 | Per-channel completion interrupt |

## Verification
The assertions assume that the processor keeps `cpu_ack` high for as long as `bus_req` stays high once the bus is acknowledged. They also assume that software does not rewrite a channel's registers while that channel is enabled. The bench models the processor as a register that follows `bus_req` one clock later, gated by a permission flag. It programs a channel only while that channel is disabled. It withholds permission when it needs several requests to be pending at the same grant. Memory read data is a fixed function of the address, so the data assertion and the bench's own checks can predict each written byte.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
    localparam int ADDR_W  = 24;
    localparam int DATA_W  = 8;
    localparam int CNT_W   = 16;
    localparam int NCH     = 2;
    localparam int GAP_CYC = 8;
    localparam int GAP_W   = $clog2(GAP_CYC + 1);

    typedef enum logic [1:0] {OWN_NONE, OWN_DMA, OWN_EXT} owner_e;
    typedef enum logic [1:0] {PH_IDLE, PH_RD, PH_WR} phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
        logic              en;
        logic              steal;
        logic [1:0]        smode;
        logic [1:0]        dmode;
        logic              ie;
        logic              done;
        logic [GAP_W-1:0]  gap;
    } chan_t;

    typedef struct packed {
        chan_t [NCH-1:0]   ch;
        phase_e            ph;
        logic              act;
        logic [DATA_W-1:0] hold;
    } eng_t;
endpackage

// File: rtl/dmx_addr_step.sv
module dmx_addr_step
    import dmx_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        mode_i,
    output logic [ADDR_W-1:0] addr_o
);
    always_comb begin
        unique case (mode_i)
            2'b00:   addr_o = addr_i + 1'b1;
            2'b01:   addr_o = addr_i - 1'b1;
            default: addr_o = addr_i;
        endcase
    end
endmodule

// File: rtl/dmx_bus_arb.sv
module dmx_bus_arb
    import dmx_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cpu_ack,
    input  logic   int_pend,
    input  logic   ext_req,
    input  logic   release_i,
    output logic   grant_dma_o,
    output owner_e owner_o
);
    owner_e owner_d, owner_q;

    always_comb begin
        owner_d     = owner_q;
        grant_dma_o = 1'b0;
        unique case (owner_q)
            OWN_NONE: begin
                if (cpu_ack && int_pend) begin
                    grant_dma_o = 1'b1;
                    owner_d     = OWN_DMA;
                end else if (cpu_ack && ext_req) begin
                    owner_d = OWN_EXT;
                end
            end
            OWN_DMA: if (release_i) owner_d = OWN_NONE;
            OWN_EXT: if (!ext_req)  owner_d = OWN_NONE;
            default: owner_d = OWN_NONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) owner_q <= OWN_NONE;
        else        owner_q <= owner_d;
    end

    assign owner_o = owner_q;
endmodule

// File: rtl/dmx_mover.sv
module dmx_mover
    import dmx_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              bus_req,
    input  logic              cpu_ack,
    input  logic              ext_breq_n,
    output logic              ext_grant,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [NCH-1:0]    irq
);
    localparam int IDX_W    = REG_AW - 1;
    localparam int ADDR_B   = ADDR_W / 8;
    localparam int CNT_B    = CNT_W / 8;
    localparam int DST_BASE = ADDR_B;
    localparam int CNT_BASE = 2 * ADDR_B;
    localparam int CTRL_IDX = CNT_BASE + CNT_B;

    eng_t              d, q;
    logic [NCH-1:0]    pend;
    logic              rel;
    logic              grant_dma;
    owner_e            owner;
    logic [ADDR_W-1:0] src_nx [NCH];
    logic [ADDR_W-1:0] dst_nx [NCH];
    logic              sel_ch;
    logic [IDX_W-1:0]  sel_idx;

    assign sel_ch  = reg_addr[REG_AW-1];
    assign sel_idx = reg_addr[IDX_W-1:0];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        dmx_addr_step u_src_step (
            .addr_i (q.ch[g].src),
            .mode_i (q.ch[g].smode),
            .addr_o (src_nx[g])
        );
        dmx_addr_step u_dst_step (
            .addr_i (q.ch[g].dst),
            .mode_i (q.ch[g].dmode),
            .addr_o (dst_nx[g])
        );
        assign pend[g] = q.ch[g].en && (q.ch[g].cnt != '0) && (q.ch[g].gap == '0);
        assign irq[g]  = q.ch[g].done && q.ch[g].ie;
    end

    dmx_bus_arb u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_ack     (cpu_ack),
        .int_pend    (|pend),
        .ext_req     (!ext_breq_n),
        .release_i   (rel),
        .grant_dma_o (grant_dma),
        .owner_o     (owner)
    );

    always_comb begin
        d   = q;
        rel = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (q.ch[i].gap != '0) d.ch[i].gap = q.ch[i].gap - 1'b1;
            if (q.ch[i].en && q.ch[i].cnt == '0) begin
                d.ch[i].en   = 1'b0;
                d.ch[i].done = 1'b1;
            end
        end
        unique case (q.ph)
            PH_IDLE: begin
                if (grant_dma) begin
                    d.act = pend[0] ? 1'b0 : 1'b1;
                    d.ph  = PH_RD;
                end
            end
            PH_RD: begin
                d.hold = mem_rdata;
                d.ph   = PH_WR;
            end
            PH_WR: begin
                d.ch[q.act].src = src_nx[q.act];
                d.ch[q.act].dst = dst_nx[q.act];
                d.ch[q.act].cnt = q.ch[q.act].cnt - 1'b1;
                if (q.ch[q.act].cnt == CNT_W'(1)) begin
                    d.ch[q.act].en   = 1'b0;
                    d.ch[q.act].done = 1'b1;
                    rel  = 1'b1;
                    d.ph = PH_IDLE;
                end else if (q.ch[q.act].steal) begin
                    d.ch[q.act].gap = GAP_W'(GAP_CYC);
                    rel  = 1'b1;
                    d.ph = PH_IDLE;
                end else begin
                    d.ph = PH_RD;
                end
            end
            default: d.ph = PH_IDLE;
        endcase
        if (reg_we) begin
            for (int k = 0; k < ADDR_B; k++) begin
                if (int'(sel_idx) == k)            d.ch[sel_ch].src[8*k +: 8] = reg_wdata;
                if (int'(sel_idx) == DST_BASE + k) d.ch[sel_ch].dst[8*k +: 8] = reg_wdata;
            end
            for (int k = 0; k < CNT_B; k++) begin
                if (int'(sel_idx) == CNT_BASE + k) d.ch[sel_ch].cnt[8*k +: 8] = reg_wdata;
            end
            if (int'(sel_idx) == CTRL_IDX) begin
                d.ch[sel_ch].en    = reg_wdata[0];
                d.ch[sel_ch].steal = reg_wdata[1];
                d.ch[sel_ch].smode = reg_wdata[3:2];
                d.ch[sel_ch].dmode = reg_wdata[5:4];
                d.ch[sel_ch].ie    = reg_wdata[6];
                d.ch[sel_ch].done  = 1'b0;
                d.ch[sel_ch].gap   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < ADDR_B; k++) begin
            if (int'(sel_idx) == k)            reg_rdata = q.ch[sel_ch].src[8*k +: 8];
            if (int'(sel_idx) == DST_BASE + k) reg_rdata = q.ch[sel_ch].dst[8*k +: 8];
        end
        for (int k = 0; k < CNT_B; k++) begin
            if (int'(sel_idx) == CNT_BASE + k) reg_rdata = q.ch[sel_ch].cnt[8*k +: 8];
        end
        if (int'(sel_idx) == CTRL_IDX)
            reg_rdata = {q.ch[sel_ch].done, q.ch[sel_ch].ie, q.ch[sel_ch].dmode,
                         q.ch[sel_ch].smode, q.ch[sel_ch].steal, q.ch[sel_ch].en};
    end

    assign mem_rd    = (q.ph == PH_RD);
    assign mem_wr    = (q.ph == PH_WR);
    assign mem_addr  = mem_rd ? q.ch[q.act].src : (mem_wr ? q.ch[q.act].dst : '0);
    assign mem_wdata = q.hold;
    assign ext_grant = (owner == OWN_EXT);
    assign bus_req   = (|pend) || !ext_breq_n || (owner != OWN_NONE);
endmodule

// File: rtl/dmx_mover_chk.sv
module dmx_mover_chk
    import dmx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              ext_grant,
    input logic              cpu_ack,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [DATA_W-1:0] mem_wdata
);
    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> mem_wr);                                           // R3
    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd));                                    // R3
    AST_DATA_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_wdata == $past(mem_rdata)));                  // R3
    AST_EXT_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        ext_grant |-> !(mem_rd || mem_wr));                           // R9
    AST_STROBE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> cpu_ack);                              // R10
endmodule

bind dmx_mover dmx_mover_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .ext_grant (ext_grant),
    .cpu_ack   (cpu_ack),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata)
);

// File: tb/dmx_mover_bench.sv
module dmx_mover_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        bus_req;
    logic        cpu_ack = 1'b0;
    logic        cpu_allow = 1'b1;
    logic        ext_breq_n = 1'b1;
    logic        ext_grant;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        mem_rd;
    logic        mem_wr;
    logic [1:0]  irq;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] fdat(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction

    function automatic logic [23:0] step(input logic [23:0] a, input int m);
        if (m == 0) return a + 24'd1;
        if (m == 1) return a - 24'd1;
        return a;
    endfunction

    assign mem_rdata = fdat(mem_addr);

    always @(posedge clk) cpu_ack <= rst_n && bus_req && cpu_allow;

    dmx_mover u_dmx_mover (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
        .cpu_ack(cpu_ack), .ext_breq_n(ext_breq_n), .ext_grant(ext_grant),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input int a, input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input int a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = 5'(a);
        #1 v = reg_rdata;
    endtask

    task automatic prog(input int c, input logic [23:0] s, input logic [23:0] d,
                        input logic [15:0] n, input logic [7:0] ctrl);
        for (int b = 0; b < 3; b++) wr_reg(c*16 + b, s[8*b +: 8]);
        for (int b = 0; b < 3; b++) wr_reg(c*16 + 3 + b, d[8*b +: 8]);
        for (int b = 0; b < 2; b++) wr_reg(c*16 + 6 + b, n[8*b +: 8]);
        wr_reg(c*16 + 8, ctrl);
    endtask

    task automatic run_xfer(input int c, input logic [23:0] s, input logic [23:0] d,
                            input int n, input int sm, input int dm, input bit st);
        logic [23:0] es = s;
        logic [23:0] ed = d;
        logic [7:0]  ctrl = {1'b0, 1'b1, 2'(dm), 2'(sm), st, 1'b1};
        logic [7:0]  v;
        logic [23:0] rs;
        int k = 0, low = 0, t = 0;
        bit exp_rd = 0;
        prog(c, s, d, 16'(n), ctrl);
        while (k < n && t < 400) begin
            @(negedge clk); t++;
            if (exp_rd) begin
                chk(mem_rd, "R5 back-to-back read", 32'(mem_rd), 1);
                exp_rd = 0;
            end
            if (mem_rd) begin
                chk(mem_addr == es, "R3/R4 read address", mem_addr, es);
                if (st && k > 0) chk(low == 8, "R6 steal gap", low, 8);
            end
            if (mem_wr) begin
                chk(mem_addr == ed, "R3/R4 write address", mem_addr, ed);
                chk(mem_wdata == fdat(es), "R3 write data", mem_wdata, fdat(es));
                es = step(es, sm); ed = step(ed, dm);
                k++; low = 0;
                if (!st && k < n) exp_rd = 1;
            end else if (!bus_req) begin
                low++;
            end
        end
        chk(k == n, "R5/R6 byte count moved", k, n);
        repeat (2) @(negedge clk);
        rd_reg(c*16 + 8, v);
        chk(v == {1'b1, ctrl[6:1], 1'b0}, "R7 done set enable cleared", v, {1'b1, ctrl[6:1], 1'b0});
        chk(irq[c], "R7 irq raised", 32'(irq), 32'(1 << c));
        for (int b = 0; b < 3; b++) begin
            rd_reg(c*16 + b, v);
            rs[8*b +: 8] = v;
        end
        chk(rs == es, "R4 final source pointer", rs, es);
        wr_reg(c*16 + 8, 8'h40);
        rd_reg(c*16 + 8, v);
        chk(v == 8'h40 && irq[c] == 1'b0, "R7 control write clears done", {v, 6'b0, irq}, 32'h4000);
        wr_reg(c*16 + 8, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0] v;
        bit bad;
        int nw;
        logic [23:0] first[4];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(!bus_req && !mem_rd && !mem_wr && !ext_grant && irq == 2'b00,
            "R1 outputs idle after reset", {bus_req, mem_rd, mem_wr, ext_grant, irq}, 0);
        bad = 0;
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < 9; i++) begin
                rd_reg(c*16 + i, v);
                if (v != 8'h00) bad = 1;
            end
        chk(!bad, "R1 registers zero after reset", 32'(bad), 0);

        // R2 register map readback
        for (int c = 0; c < 2; c++) begin
            for (int i = 0; i < 8; i++) wr_reg(c*16 + i, 8'(8'h11 * (i + 1) + c));
            wr_reg(c*16 + 8, 8'h7E);
            for (int i = 0; i < 8; i++) begin
                rd_reg(c*16 + i, v);
                chk(v == 8'(8'h11 * (i + 1) + c), "R2 register readback", v, 8'(8'h11 * (i + 1) + c));
            end
            rd_reg(c*16 + 8, v);
            chk(v == 8'h7E, "R2 control readback", v, 8'h7E);
            rd_reg(c*16 + 9, v);
            chk(v == 8'h00, "R2 unused index reads zero", v, 0);
            wr_reg(c*16 + 8, 8'h00);
        end

        // R10 disabled channel with nonzero count never requests
        prog(0, 24'h000010, 24'h000020, 16'd5, 8'h00);
        bad = 0;
        repeat (20) begin @(negedge clk); if (bus_req) bad = 1; end
        chk(!bad, "R10 disabled channel quiet", 32'(bad), 0);

        // R3 R4 R5 R6 R7 sweep over channels, step modes, transfer modes
        for (int c = 0; c < 2; c++)
            for (int sm = 0; sm < 3; sm++)
                for (int dm = 0; dm < 3; dm++)
                    for (int st = 0; st < 2; st++)
                        run_xfer(c, 24'h000001, 24'hFFFFFE, 3, (sm == 2) ? 2 : sm, (dm == 2) ? 2 : dm, st[0]);

        // R8 zero count
        prog(1, 24'h000100, 24'h000200, 16'd0, 8'h41);
        bad = 0;
        repeat (6) begin @(negedge clk); if (bus_req || mem_rd || mem_wr) bad = 1; end
        chk(!bad, "R8 zero count makes no bus activity", 32'(bad), 0);
        rd_reg(24, v);
        chk(v == 8'hC0, "R8 zero count completes", v, 8'hC0);
        chk(irq[1], "R8 zero count interrupt", 32'(irq), 2);
        wr_reg(24, 8'h00);

        // R11 channel 0 served first
        cpu_allow = 1'b0;
        prog(1, 24'h200000, 24'h210000, 16'd2, 8'h01);
        prog(0, 24'h100000, 24'h110000, 16'd2, 8'h01);
        @(negedge clk); cpu_allow = 1'b1;
        nw = 0;
        for (int t = 0; t < 100 && nw < 4; t++) begin
            @(negedge clk);
            if (mem_rd) begin first[nw] = mem_addr; nw++; end
        end
        chk(first[0] == 24'h100000 && first[1] == 24'h100001, "R11 channel 0 first",
            first[0], 24'h100000);
        chk(first[2] == 24'h200000 && first[3] == 24'h200001, "R11 channel 1 afterwards",
            first[2], 24'h200000);
        repeat (3) @(negedge clk);
        wr_reg(8, 8'h00); wr_reg(24, 8'h00);

        // R9 simultaneous request: channel wins, external after
        cpu_allow = 1'b0; ext_breq_n = 1'b0;
        prog(0, 24'h300000, 24'h310000, 16'd3, 8'h01);
        @(negedge clk); cpu_allow = 1'b1;
        nw = 0; bad = 0;
        for (int t = 0; t < 60 && nw < 3; t++) begin
            @(negedge clk);
            if (ext_grant) bad = 1;
            if (mem_wr) nw++;
        end
        chk(!bad && nw == 3, "R9 channel beats external", {bad, 8'(nw)}, 3);
        repeat (3) @(negedge clk);
        chk(ext_grant, "R9 external granted after release", 32'(ext_grant), 1);
        // external holds bus: new channel request waits
        prog(1, 24'h400000, 24'h410000, 16'd1, 8'h01);
        bad = 0;
        repeat (10) begin @(negedge clk); if (mem_rd || mem_wr || !ext_grant) bad = 1; end
        chk(!bad, "R9 no strobes while external owns bus", 32'(bad), 0);
        ext_breq_n = 1'b1;
        nw = 0;
        for (int t = 0; t < 20; t++) begin @(negedge clk); if (mem_wr) nw++; end
        chk(nw == 1 && !ext_grant, "R9 channel runs after external leaves", nw, 1);
        wr_reg(8, 8'h00); wr_reg(24, 8'h00);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule